// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block programs a target FPGA through a passive serial link. A start pulse makes it pull the target's active-low configuration request low for a short reset pulse. It then checks that the target's status line went low, releases the request and polls until the status line rises. After a settle delay it takes image bytes from a valid/ready byte stream. It shifts each byte onto a data pin under a generated serial clock, least significant bit first.

After the last byte it checks the status line and, if enabled, the target's configuration-done line. It then clocks out one all-zero byte so the target gets the extra clock edges it needs to enter user mode. The outcome is reported on `busy`, `cfg_done` and a 3-bit error code, and both results stay in place until the next start. All delays are counted in microseconds from a tick derived from `CLK_HZ`. A device-type input picks between a standard and a large timing profile.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, `cfg_req_n` is 1, `dclk` is 0, and `busy`, `cfg_done`, `s_ready` and `err` are all 0.
- R2: A start with `partial` = 1 while idle sets `err` to 5 on the next cycle. `cfg_req_n` never goes low and `busy` stays 0.
- R3: A start while idle pulls `cfg_req_n` low for at least `T_CFG_US` (2) µs and less than `T_CFG_US`+1 µs.
- R4: If `tgt_status` is high at the end of the reset pulse, the block sets `err` to 1, releases `cfg_req_n`, goes idle and produces no `dclk` edge.
- R5: After release the block samples `tgt_status` every 268 µs. It takes up to 6 samples for the standard profile (`dev_big` = 0) and up to 12 for the large profile. If none of them is high, it sets `err` to 2 with no `dclk` edge.
- R6: The first rising `dclk` edge comes at least 2 µs (standard) or 10 µs (large) after the sample that saw `tgt_status` high.
- R7: Each byte goes out on `dout` least significant bit first. `dout` changes only as `dclk` falls, so it is stable at every rising edge.
- R8: `s_ready` is high only while the block waits for a byte. Every accepted byte is sent exactly once and in order. The byte that has `s_last` = 1 is the final image byte.
- R9: If `tgt_status` is low after the final image byte, the block sets `err` to 3 and sends no trailing byte.
- R10: When `use_done` = 1 and `tgt_done` is low after the final image byte, the block sets `err` to 4. When `use_done` = 0, `tgt_done` is ignored.
- R11: When all checks pass, the block sends one trailing 0x00 byte, then sets `cfg_done` = 1 with `err` = 0 and drops `busy`.
- R12: A start while `busy` is ignored. `err` and `cfg_done` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (single-cycle pulse, taken only when idle) |
| partial | input | 1 | Request is a partial reconfiguration (rejected) |
| dev_big | input | 1 | 0 = standard timing profile, 1 = large profile |
| use_done | input | 1 | 1 = check `tgt_done` before the trailing byte |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block accepts an image byte |
| tgt_status | input | 1 | Target status, low while in reset or in error |
| tgt_done | input | 1 | Target configuration-done flag, active high |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| dclk | output | 1 | Serial clock |
| dout | output | 1 | Serial data |
| busy | output | 1 | Load in progress |
| cfg_done | output | 1 | Last load completed without error |
| err | output | 3 | 0 none, 1 no reset seen, 2 not ready, 3 config error, 4 done inactive, 5 partial rejected |

## Verification
A partial-reconfiguration rejection is due one cycle after the start pulse. The reset pulse width is checked within one microsecond tick. The first serial clock rise is due inside a window fixed by the poll index at which the target reports ready plus the settle time, measured from the release of the request. The status inputs are synchronised, so the bench chooses the target's ready time in the middle of a poll interval and never near a poll boundary. Every other result is read one falling clock edge after `busy` drops, with all sampling done on falling edges.

// File: rtl/ps_cfg_master.sv
module ps_cfg_master #(
  parameter int CLK_HZ        = 250_000_000,
  parameter int SCK_HALF      = 2,
  parameter int T_CFG_US      = 2,
  parameter int POLL_US       = 268,
  parameter int STD_MAX_US    = 1506,
  parameter int BIG_MAX_US    = 3000,
  parameter int STD_SETTLE_US = 2,
  parameter int BIG_SETTLE_US = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       partial,
  input  logic       dev_big,
  input  logic       use_done,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  input  logic       tgt_status,
  input  logic       tgt_done,
  output logic       cfg_req_n,
  output logic       dclk,
  output logic       dout,
  output logic       busy,
  output logic       cfg_done,
  output logic [2:0] err
);

  localparam int US_DIV    = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int US_W      = $clog2(US_DIV) + 1;
  localparam int STD_POLLS = (STD_MAX_US + POLL_US - 1) / POLL_US;
  localparam int BIG_POLLS = (BIG_MAX_US + POLL_US - 1) / POLL_US;
  localparam int MAX_POLLS = (STD_POLLS > BIG_POLLS) ? STD_POLLS : BIG_POLLS;
  localparam int POLL_W    = $clog2(MAX_POLLS) + 1;
  localparam int TMR_W     = $clog2(POLL_US + T_CFG_US + STD_SETTLE_US + BIG_SETTLE_US + 2);
  localparam int DIV_W     = $clog2(SCK_HALF) + 1;

  localparam logic [2:0] E_NONE   = 3'd0;
  localparam logic [2:0] E_NORST  = 3'd1;
  localparam logic [2:0] E_NOTRDY = 3'd2;
  localparam logic [2:0] E_CFG    = 3'd3;
  localparam logic [2:0] E_NODONE = 3'd4;
  localparam logic [2:0] E_PART   = 3'd5;

  typedef enum logic [2:0] {IDLE, RST, POLL, SETTLE, WAITB, SHIFT, CHECK} st_t;

  st_t              state;
  logic [US_W-1:0]  us_cnt;
  logic [TMR_W-1:0] tmr, lim;
  logic [POLL_W-1:0] polls, poll_lim;
  logic [1:0]       st_s, dn_s;
  logic [7:0]       sh;
  logic [2:0]       nbit;
  logic [DIV_W-1:0] div;
  logic             dclk_q, last_q, tail_q, big_q, chk_q, done_q;
  logic [2:0]       err_q;

  wire tick = (us_cnt == US_W'(US_DIV - 1));
  wire hit  = tick && (tmr == lim);

  always_comb begin
    case (state)
      RST:     lim = TMR_W'(T_CFG_US);
      POLL:    lim = TMR_W'(POLL_US);
      SETTLE:  lim = big_q ? TMR_W'(BIG_SETTLE_US) : TMR_W'(STD_SETTLE_US);
      default: lim = '0;
    endcase
  end

  assign poll_lim  = big_q ? POLL_W'(BIG_POLLS - 1) : POLL_W'(STD_POLLS - 1);
  assign s_ready   = (state == WAITB);
  assign cfg_req_n = (state != RST);
  assign busy      = (state != IDLE);
  assign dclk      = dclk_q;
  assign dout      = sh[0];
  assign cfg_done  = done_q;
  assign err       = err_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    us_cnt <= '0;
    else if (tick) us_cnt <= '0;
    else           us_cnt <= us_cnt + US_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      tmr    <= '0;
      polls  <= '0;
      st_s   <= '0;
      dn_s   <= '0;
      sh     <= '0;
      nbit   <= '0;
      div    <= '0;
      dclk_q <= 1'b0;
      last_q <= 1'b0;
      tail_q <= 1'b0;
      big_q  <= 1'b0;
      chk_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= E_NONE;
    end else begin
      st_s <= {st_s[0], tgt_status};
      dn_s <= {dn_s[0], tgt_done};
      if (tick) tmr <= tmr + TMR_W'(1);
      case (state)
        IDLE:
          if (start) begin
            done_q <= 1'b0;
            if (partial) err_q <= E_PART;
            else begin
              err_q <= E_NONE;
              big_q <= dev_big;
              chk_q <= use_done;
              polls <= '0;
              tmr   <= '0;
              state <= RST;
            end
          end
        RST:
          if (hit) begin
            tmr <= '0;
            if (st_s[1]) begin
              err_q <= E_NORST;
              state <= IDLE;
            end else state <= POLL;
          end
        POLL:
          if (hit) begin
            tmr <= '0;
            if (st_s[1]) state <= SETTLE;
            else if (polls == poll_lim) begin
              err_q <= E_NOTRDY;
              state <= IDLE;
            end else polls <= polls + POLL_W'(1);
          end
        SETTLE:
          if (hit) state <= WAITB;
        WAITB:
          if (s_valid) begin
            sh     <= s_data;
            last_q <= s_last;
            tail_q <= 1'b0;
            nbit   <= '0;
            div    <= '0;
            state  <= SHIFT;
          end
        SHIFT:
          if (div == DIV_W'(SCK_HALF - 1)) begin
            div    <= '0;
            dclk_q <= ~dclk_q;
            if (dclk_q) begin
              sh   <= {1'b0, sh[7:1]};
              nbit <= nbit + 3'd1;
              if (nbit == 3'd7) begin
                if (tail_q) begin
                  done_q <= 1'b1;
                  state  <= IDLE;
                end else if (last_q) state <= CHECK;
                else state <= WAITB;
              end
            end
          end else div <= div + DIV_W'(1);
        CHECK:
          if (!st_s[1]) begin
            err_q <= E_CFG;
            state <= IDLE;
          end else if (chk_q && !dn_s[1]) begin
            err_q <= E_NODONE;
            state <= IDLE;
          end else begin
            sh     <= '0;
            tail_q <= 1'b1;
            nbit   <= '0;
            div    <= '0;
            state  <= SHIFT;
          end
        default: state <= IDLE;
      endcase
    end
  end

  assert_req_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_req_n |-> busy);

  assert_data_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dclk) |-> $stable(dout));

  assert_ready_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (cfg_req_n && !dclk));

  assert_partial_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && partial && !busy) |=> (err == 3'd5 && cfg_req_n && !busy));

  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err) && $stable(cfg_done)));

  assert_done_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (err == 3'd0 && !busy));

  assert_notready_noclk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err == 3'd2) |-> !dclk);

endmodule

// File: tb/ps_cfg_master_bench.sv
module ps_cfg_master_bench;
  localparam int US  = 4;
  localparam int HLF = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, partial = 0, dev_big = 0, use_done = 0;
  logic [7:0] s_data = 0;
  logic s_valid = 0, s_last = 0, s_ready;
  logic tgt_status = 1'b1, tgt_done = 1'b0;
  logic cfg_req_n, dclk, dout, busy, cfg_done;
  logic [2:0] err;

  int checks = 0, fails = 0;
  int unsigned cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  ps_cfg_master #(.CLK_HZ(US * 1_000_000), .SCK_HALF(HLF)) u_ps_cfg_master (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .dev_big(dev_big),
    .use_done(use_done), .s_data(s_data), .s_valid(s_valid), .s_last(s_last),
    .s_ready(s_ready), .tgt_status(tgt_status), .tgt_done(tgt_done),
    .cfg_req_n(cfg_req_n), .dclk(dclk), .dout(dout), .busy(busy),
    .cfg_done(cfg_done), .err(err));

  // target model
  bit reset_ok = 1, force_low = 0;
  int unsigned ready_cyc = 0, rel = 0;
  always @(negedge clk) begin
    if (!cfg_req_n) begin
      rel = 0;
      tgt_status = reset_ok ? 1'b0 : 1'b1;
    end else begin
      if (rel < 32'hFFFF_0000) rel++;
      if (reset_ok) tgt_status = (rel >= ready_cyc) && !force_low;
    end
  end

  // serial receiver, LSB first
  logic [7:0] rx_sh = 0;
  logic [7:0] rx_mem [64];
  int rx_bits = 0, rx_total = 0;
  always @(posedge dclk) begin
    rx_sh = {dout, rx_sh[7:1]};
    rx_bits++;
    if (rx_bits == 8) begin
      rx_mem[rx_total % 64] = rx_sh;
      rx_total++;
      rx_bits = 0;
    end
  end

  logic [7:0] tx [8];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_err(bit rok, int j, bit flow, bit ud, bit dn);
    if (!rok) return 1;
    if (j < 0) return 2;
    if (flow) return 3;
    if (ud && !dn) return 4;
    return 0;
  endfunction

  task automatic run(input bit big, input bit rok, input int j, input bit flow,
                     input bit ud, input bit dn, input int n, input bit fixed, input bit poke);
    int base, t0, t1, t2, e, settle, lo, hi, nexp;
    e = exp_err(rok, j, flow, ud, dn);
    settle = big ? 10 : 2;
    for (int i = 0; i < n; i++) tx[i] = fixed ? ((i == 0) ? 8'h01 : (i == 1) ? 8'h80 : 8'hA5) : 8'($urandom);
    reset_ok = rok; force_low = 0;
    ready_cyc = (j < 0) ? 32'h7FFF_FFFF : (268 * j + 20 + $urandom % 220) * US;
    dev_big = big; use_done = ud; tgt_done = dn;
    base = rx_total;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    t0 = cyc;
    while (!cfg_req_n) @(negedge clk);
    t1 = cyc;
    chk((t1 - t0) >= 2 * US && (t1 - t0) <= 3 * US + 1, "R3", "reset pulse cycles", t1 - t0, 3 * US);
    if (!rok) begin
      @(negedge clk);
      chk(err == 3'd1 && !busy, "R4", "err after missing reset", err, 1);
      chk(rx_total == base && rx_bits == 0, "R4", "bytes sent", rx_total - base, 0);
      return;
    end
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1;
      @(negedge clk) start = 0;
      for (int k = 0; k < 10; k++) begin
        chk(cfg_req_n == 1'b1, "R12", "request during busy start", cfg_req_n, 1);
        @(negedge clk);
      end
    end
    if (j < 0) begin
      while (busy) @(negedge clk);
      chk(err == 3'd2 && !cfg_done, "R5", "err not ready", err, 2);
      chk(rx_total == base && rx_bits == 0, "R5", "bytes sent", rx_total - base, 0);
      return;
    end
    for (int i = 0; i < n; i++) begin
      s_data = tx[i]; s_valid = 1; s_last = (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 0; s_last = 0;
      if (i == 0) begin
        while (!dclk) @(negedge clk);
        t2 = cyc;
        lo = (j + 1) * 268 * US + settle * US;
        hi = (j + 1) * 269 * US + (settle + 1) * US + 20;
        chk((t2 - t1) >= lo && (t2 - t1) <= hi, "R6", "first dclk rise", t2 - t1, lo);
      end
      if (i == n - 1 && flow) force_low = 1;
    end
    while (busy) @(negedge clk);
    chk(err == 3'(e), (e == 3) ? "R9" : (e == 4) ? "R10" : "R11", "err at end", err, e);
    chk(cfg_done == (e == 0), "R11", "done flag", cfg_done, e == 0);
    nexp = n + ((e == 0) ? 1 : 0);
    chk(rx_total - base == nexp, "R8", "byte count", rx_total - base, nexp);
    for (int i = 0; i < n; i++)
      chk(rx_mem[(base + i) % 64] == tx[i], "R7", "byte value LSB first", rx_mem[(base + i) % 64], tx[i]);
    if (e == 0) chk(rx_mem[(base + n) % 64] == 8'h00, "R11", "trailing byte", rx_mem[(base + n) % 64], 0);
    chk(!s_ready && !dclk && cfg_req_n, "R8", "idle pins", s_ready, 0);
    repeat (20) @(negedge clk);
    chk(err == 3'(e) && cfg_done == (e == 0), "R12", "result held", err, e);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk(cfg_req_n && !dclk && !busy && !cfg_done && !s_ready && err == 0, "R1", "reset state", err, 0);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_req_n && !dclk && !busy && !cfg_done && !s_ready && err == 0, "R1", "after reset release", busy, 0);

    partial = 1; start = 1;
    @(negedge clk) begin start = 0; partial = 0; end
    chk(err == 3'd5 && !busy && cfg_req_n, "R2", "partial rejected", err, 5);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(cfg_req_n && !busy, "R2", "request untouched", cfg_req_n, 1);
    end

    run(0, 0, 0, 0, 0, 0, 1, 1, 0);     // R4
    run(0, 1, 2, 0, 0, 0, 3, 1, 1);     // R6 R7 R11 R12 standard
    run(1, 1, 10, 0, 1, 1, 2, 0, 0);    // R5 R6 large profile beyond standard limit
    run(0, 1, -1, 0, 0, 0, 2, 0, 0);    // R5 not ready
    run(0, 1, 0, 1, 0, 0, 2, 0, 0);     // R9
    run(0, 1, 1, 0, 1, 0, 2, 0, 0);     // R10 done inactive
    run(0, 1, 0, 0, 0, 0, 1, 0, 0);     // R10 done check skipped
    for (int it = 0; it < 4; it++) begin
      bit b; int jj;
      b = 1'($urandom % 2);
      jj = ($urandom % 5 == 0) ? -1 : int'($urandom % (b ? 12 : 6));
      run(b, 1, jj, ($urandom % 4) == 0, 1'($urandom % 2), 1'($urandom % 2), 1 + $urandom % 4, 0, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule